// File: doc/BRIEF.md
# Extended-Precision Exponent and Significand Extractor

This unit takes one 80-bit extended-precision floating-point operand and splits it into one of its two parts. The operand has a sign bit at bit 79, a 15-bit biased exponent at bits 78:64 and a 64-bit significand at bits 63:0. The significand carries its integer bit explicitly at bit 63. The operation select chooses between two results. One is the operand's unbiased exponent, written back as an extended-precision number. The other is the operand's significand, rescaled so its exponent is the bias and given the operand's own sign.

Special encodings are handled before any extraction takes place:
- A NaN is passed through with its quiet bit forced on.
- An infinity is rejected with the default NaN.
- A zero is returned as a zero of the same sign.
- A subnormal is first normalized with a leading-zero count.

The result and an invalid-operation flag are registered, so they appear one clock after the request. Results always keep the full 64-bit significand and are never rounded.

Top module: `xf_expman_unit`

## Requirements
- R1: A request sampled with `in_valid_i` high produces `out_valid_o` high on the next clock edge. `out_valid_o` is low after any edge at which `in_valid_i` was low. Synchronous reset clears `out_valid_o`, `result_o` and `invalid_o` to zero.
- R2: An operand is a NaN when its exponent field is 0x7FFF and any of significand bits 62:0 is set. The result is then the operand with significand bit 62 (the quiet bit) set. `invalid_o` is 1 exactly when bit 62 was clear (a signaling NaN). This applies to both operations.
- R3: An operand is an infinity when its exponent field is 0x7FFF and significand bits 62:0 are zero. Bit 63 does not matter. The result is then the default NaN: sign 0, exponent 0x7FFF, significand 0xC000_0000_0000_0000, with `invalid_o` = 1. This applies to both operations.
- R4: An operand with exponent 0 and significand 0 yields a result that is all zero except for bit 79, which copies the operand's sign. This applies to both operations.
- R5: An operand with exponent 0 and a nonzero significand is normalized first. Its significand is shifted left by its leading-zero count n, and its working exponent becomes 1 − n. Any other finite operand uses its exponent field as the working exponent, with its significand unchanged.
- R6: `op_i` = 0 selects the get-exponent operation and `op_i` = 1 selects the get-mantissa operation.
- R7: Get-exponent computes the signed integer d = working exponent − 16383 and converts it exactly:
  - When d = 0, the result is +0 (all 80 bits zero).
  - Otherwise the sign is 1 when d < 0, and the significand is |d| shifted left by the leading-zero count z of |d| in a 64-bit field.
  - The exponent is 16383 + 63 − z.
- R8: Get-mantissa returns the operand's sign, exponent 0x3FFF and the working significand from R5.
- R9: `invalid_o` is 0 for every operand that is neither a NaN nor an infinity.
- R10: While `in_valid_i` is low, `result_o` and `invalid_o` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid_i | input | 1 | Request strobe; the operand and the operation select are sampled when high |
| op_i | input | 1 | 0 = get exponent, 1 = get mantissa |
| operand_i | input | 80 | Extended-precision operand |
| out_valid_o | output | 1 | Result valid, one cycle after the request |
| result_o | output | 80 | Extended-precision result |
| invalid_o | output | 1 | Invalid-operation flag for the registered result |

## Verification
The bench builds the unit with its default widths: a 15-bit exponent and a 64-bit significand. With these widths, the smallest subnormal needs the full 63-place normalization shift and yields a working exponent of −62. This gives the largest negative exponent difference, −16445. The largest finite exponent gives +16383, and the bias itself gives the zero-difference case. Random operands spread over the normal, subnormal, zero, infinity and NaN classes, mixed with directed operands at these extremes, exercise every branch of the leading-zero counters and of the integer-to-float conversion.

// File: rtl/xf_pkg.sv
// Package: shared operation encoding and field helpers for the extended
// float exponent/mantissa extractor. Assumes a sign | exponent | significand
// layout with an explicit integer bit at the top of the significand.
package xf_pkg;

    // Operation select; the encoding is fixed by the op_i port contract.
    typedef enum logic {
        XOP_GETEXP = 1'b0,
        XOP_GETMAN = 1'b1
    } xf_op_e;

    // Class flags produced by the operand classifier.
    typedef struct packed {
        logic is_nan;
        logic is_snan;
        logic is_inf;
        logic is_zero;
        logic is_sub;
    } xf_class_t;

endpackage

// File: rtl/xf_lzc.sv
// Module: leading-zero counter.
// Counts the zeros above the most significant set bit of vec. Returns W when
// vec is all zero. Purely combinational; W may be any positive width.
module xf_lzc #(
    parameter int W  = 64,
    parameter int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  vec,
    output logic [CW-1:0] count
);

    // Scan upward so the highest set bit decides the final count.
    always_comb begin
        count = CW'(W);
        for (int i = 0; i < W; i++) begin
            if (vec[i]) begin
                count = CW'(W - 1 - i);
            end
        end
    end

endmodule

// File: rtl/xf_classify.sv
// Module: operand classifier.
// Splits an extended operand's exponent and significand into NaN / signaling
// NaN / infinity / zero / subnormal flags. Assumes the quiet bit sits just
// below the explicit integer bit, and that the integer bit is ignored when
// telling an infinity from a NaN.
module xf_classify
    import xf_pkg::*;
#(
    parameter int EXP_W = 15,
    parameter int SIG_W = 64
) (
    input  logic [EXP_W-1:0] exp_i,
    input  logic [SIG_W-1:0] sig_i,
    output xf_class_t        cls_o
);

    logic exp_ones;
    logic exp_zero;
    logic frac_nz;

    // Derive the raw field predicates.
    always_comb begin
        exp_ones = &exp_i;
        exp_zero = ~|exp_i;
        frac_nz  = |sig_i[SIG_W-2:0];
    end

    // Combine predicates into mutually exclusive class flags.
    always_comb begin
        cls_o.is_nan  = exp_ones & frac_nz;
        cls_o.is_snan = exp_ones & frac_nz & ~sig_i[SIG_W-2];
        cls_o.is_inf  = exp_ones & ~frac_nz;
        cls_o.is_zero = exp_zero & ~|sig_i;
        cls_o.is_sub  = exp_zero & |sig_i;
    end

endmodule

// File: rtl/xf_int2fp.sv
// Module: exact signed-integer to extended-float converter.
// Converts a two's-complement value of INT_W bits into sign, biased exponent
// and normalized significand. Assumes INT_W <= SIG_W, so the conversion is
// always exact. A zero input gives an all-zero (positive zero) encoding.
module xf_int2fp #(
    parameter int EXP_W = 15,
    parameter int SIG_W = 64,
    parameter int INT_W = 17
) (
    input  logic [INT_W-1:0] ival_i,
    output logic             sign_o,
    output logic [EXP_W-1:0] exp_o,
    output logic [SIG_W-1:0] sig_o
);

    localparam int BIAS = (1 << (EXP_W - 1)) - 1;
    localparam int LZ_W = $clog2(SIG_W + 1);

    logic             neg;
    logic [INT_W-1:0] mag;
    logic [SIG_W-1:0] mag_ext;
    logic [LZ_W-1:0]  lz;

    // Take the magnitude of the two's-complement input.
    always_comb begin
        neg     = ival_i[INT_W-1];
        mag     = neg ? (~ival_i + INT_W'(1)) : ival_i;
        mag_ext = SIG_W'(mag);
    end

    xf_lzc #(.W(SIG_W), .CW(LZ_W)) u_lzc (
        .vec   (mag_ext),
        .count (lz)
    );

    // Pack the normalized magnitude; a zero input stays all zero.
    always_comb begin
        if (mag_ext == '0) begin
            sign_o = 1'b0;
            exp_o  = '0;
            sig_o  = '0;
        end else begin
            sign_o = neg;
            exp_o  = EXP_W'(BIAS + SIG_W - 1) - EXP_W'(lz);
            sig_o  = mag_ext << lz;
        end
    end

endmodule

// File: rtl/xf_expman_unit.sv
// Module: extended float get-exponent / get-mantissa unit (top).
// One request per cycle; result and invalid flag are registered, one cycle
// latency. Handles NaN, infinity, zero and subnormal operands before the
// extraction. No rounding: results keep the full significand width.
// Reset is synchronous and active low.
module xf_expman_unit
    import xf_pkg::*;
#(
    parameter int EXP_W = 15,
    parameter int SIG_W = 64
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         in_valid_i,
    input  logic                         op_i,
    input  logic [EXP_W+SIG_W:0]         operand_i,
    output logic                         out_valid_o,
    output logic [EXP_W+SIG_W:0]         result_o,
    output logic                         invalid_o
);

    localparam int TOT_W  = 1 + EXP_W + SIG_W;
    localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
    localparam int LZ_W   = $clog2(SIG_W + 1);
    localparam int WEXP_W = EXP_W + 2;
    localparam logic [TOT_W-1:0] DFLT_NAN =
        {1'b0, {EXP_W{1'b1}}, 2'b11, {(SIG_W-2){1'b0}}};
    localparam logic [TOT_W-1:0] QUIET_MASK = TOT_W'(1) << (SIG_W - 2);

    logic               op_sign;
    logic [EXP_W-1:0]   op_exp;
    logic [SIG_W-1:0]   op_sig;
    xf_op_e             op_sel;
    xf_class_t          cls;
    logic [LZ_W-1:0]    sig_lz;
    logic [SIG_W-1:0]   norm_sig;
    logic [WEXP_W-1:0]  wexp;
    logic [WEXP_W-1:0]  dval;
    logic               i2f_sign;
    logic [EXP_W-1:0]   i2f_exp;
    logic [SIG_W-1:0]   i2f_sig;
    logic [TOT_W-1:0]   res_d;
    logic               inv_d;

    // Split the operand into its fields and decode the operation.
    always_comb begin
        op_sign = operand_i[TOT_W-1];
        op_exp  = operand_i[TOT_W-2:SIG_W];
        op_sig  = operand_i[SIG_W-1:0];
        op_sel  = xf_op_e'(op_i);
    end

    xf_classify #(.EXP_W(EXP_W), .SIG_W(SIG_W)) u_cls (
        .exp_i (op_exp),
        .sig_i (op_sig),
        .cls_o (cls)
    );

    xf_lzc #(.W(SIG_W), .CW(LZ_W)) u_sig_lzc (
        .vec   (op_sig),
        .count (sig_lz)
    );

    // Normalize subnormals and form the working exponent and difference.
    always_comb begin
        if (cls.is_sub) begin
            norm_sig = op_sig << sig_lz;
            wexp     = WEXP_W'(1) - WEXP_W'(sig_lz);
        end else begin
            norm_sig = op_sig;
            wexp     = WEXP_W'(op_exp);
        end
        dval = wexp - WEXP_W'(BIAS);
    end

    xf_int2fp #(.EXP_W(EXP_W), .SIG_W(SIG_W), .INT_W(WEXP_W)) u_i2f (
        .ival_i (dval),
        .sign_o (i2f_sign),
        .exp_o  (i2f_exp),
        .sig_o  (i2f_sig)
    );

    // Pick the result by operand class first, then by operation.
    always_comb begin
        inv_d = 1'b0;
        if (cls.is_nan) begin
            res_d = operand_i | QUIET_MASK;
            inv_d = cls.is_snan;
        end else if (cls.is_inf) begin
            res_d = DFLT_NAN;
            inv_d = 1'b1;
        end else if (cls.is_zero) begin
            res_d = {op_sign, {(TOT_W-1){1'b0}}};
        end else if (op_sel == XOP_GETEXP) begin
            res_d = {i2f_sign, i2f_exp, i2f_sig};
        end else begin
            res_d = {op_sign, EXP_W'(BIAS), norm_sig};
        end
    end

    // Output register: valid follows the request, data holds when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid_o <= 1'b0;
            result_o    <= '0;
            invalid_o   <= 1'b0;
        end else begin
            out_valid_o <= in_valid_i;
            if (in_valid_i) begin
                result_o  <= res_d;
                invalid_o <= inv_d;
            end
        end
    end

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid_i |=> out_valid_o); // R1
    AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid_i |=> !out_valid_o); // R1
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid_i |=> ($stable(result_o) && $stable(invalid_o))); // R10
    AST_NAN_QUIETED: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && cls.is_nan) |=> (result_o[SIG_W-2] && &result_o[TOT_W-2:SIG_W])); // R2
    AST_INF_DEFAULT_NAN: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && cls.is_inf) |=> (invalid_o && result_o == DFLT_NAN)); // R3
    AST_SUB_NORMALIZED: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && cls.is_sub) |-> norm_sig[SIG_W-1]); // R5
    AST_MAN_BIAS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && op_sel == XOP_GETMAN && !cls.is_nan && !cls.is_inf && !cls.is_zero)
        |=> (result_o[TOT_W-2:SIG_W] == EXP_W'(BIAS))); // R8
    AST_EXP_NORMALIZED: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && op_sel == XOP_GETEXP && !cls.is_nan && !cls.is_inf && !cls.is_zero
         && dval != '0) |=> result_o[SIG_W-1]); // R7
    AST_INVALID_SPECIAL: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && invalid_o) |-> &result_o[TOT_W-2:SIG_W]); // R9

endmodule

// File: tb/tb_xf_expman_unit.sv
`timescale 1ns/100ps
// Bench: random and directed operands against a behavioural model.
module tb_xf_expman_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid_i = 1'b0;
    logic        op_i = 1'b0;
    logic [79:0] operand_i = '0;
    logic        out_valid_o;
    logic [79:0] result_o;
    logic        invalid_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    xf_expman_unit dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid_i  (in_valid_i),
        .op_i        (op_i),
        .operand_i   (operand_i),
        .out_valid_o (out_valid_o),
        .result_o    (result_o),
        .invalid_o   (invalid_o)
    );

    always #2.5 clk = ~clk;

    // Leading zeros of a 64-bit value (64 for zero).
    function automatic int lz64(logic [63:0] v);
        for (int i = 63; i >= 0; i--) begin
            if (v[i]) return 63 - i;
        end
        return 64;
    endfunction

    // Expected {invalid, result} from the requirements.
    function automatic logic [80:0] model(bit op, logic [79:0] x);
        logic [14:0] e;
        logic [63:0] s;
        logic [63:0] mag;
        int          we;
        int          d;
        int          z;
        e = x[78:64];
        s = x[63:0];
        if (e == 15'h7FFF && s[62:0] != 0) return {~s[62], x | (80'd1 << 62)};           // R2
        if (e == 15'h7FFF) return {1'b1, 16'h7FFF, 64'hC000_0000_0000_0000};            // R3
        if (e == 0 && s == 0) return {1'b0, x[79], 79'd0};                              // R4
        if (e == 0) begin z = lz64(s); s = s << z; we = 1 - z; end else we = int'(e);   // R5
        if (op) return {1'b0, x[79], 15'h3FFF, s};                                      // R8
        d = we - 16383;                                                                 // R7
        if (d == 0) return 81'd0;
        mag = 64'(d < 0 ? -d : d);
        z = lz64(mag);
        return {1'b0, d < 0, 15'(16383 + 63 - z), mag << z};
    endfunction

    // Requirement tag for an operand/operation pair.
    function automatic string tag_of(bit op, logic [79:0] x);
        if (x[78:64] == 15'h7FFF) return (x[62:0] != 0) ? "R2" : "R3";
        if (x[78:64] == 0 && x[63:0] == 0) return "R4";
        if (x[78:64] == 0) return op ? "R5/R8" : "R5/R7";
        return op ? "R6/R8" : "R6/R7";
    endfunction

    task automatic check(string req, logic [80:0] act, logic [80:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Send one request, check the registered result, then the idle hold.
    task automatic apply(bit op, logic [79:0] x);
        logic [80:0] exp;
        string       t;
        exp = model(op, x);
        t = tag_of(op, x);
        @(negedge clk);
        in_valid_i = 1'b1;
        op_i       = op;
        operand_i  = x;
        @(negedge clk);
        in_valid_i = 1'b0;
        operand_i  = ~x;
        op_i       = ~op;
        check({t, " R1 valid"}, {80'd0, out_valid_o}, 81'd1);
        check({t, " result"}, {1'b0, result_o}, {1'b0, exp[79:0]});
        check(exp[80] ? {t, " invalid"} : "R9 invalid", {80'd0, invalid_o}, {80'd0, exp[80]});
        @(negedge clk);
        check("R10 hold", {out_valid_o, result_o}, {1'b0, exp[79:0]});
    endtask

    // Random operand of a random class.
    function automatic logic [79:0] rand_op();
        logic [63:0] s;
        logic [14:0] e;
        s = {$urandom, $urandom};
        case ($urandom % 6)
            0, 1: begin e = 15'($urandom % 32766 + 1); if ($urandom % 4 != 0) s[63] = 1'b1; end
            2: begin e = 0; s = s >> ($urandom % 64); if (s == 0) s = 64'd1; end
            3: begin e = 0; s = 0; end
            4: begin e = 15'h7FFF; s[62:0] = 0; end
            default: begin e = 15'h7FFF; if (s[62:0] == 0) s[0] = 1'b1; end
        endcase
        return {1'($urandom), e, s};
    endfunction

    initial begin
        void'($urandom(32'd20240601));
        repeat (3) @(negedge clk);
        check("R1 reset", {out_valid_o, result_o}, 81'd0);
        check("R1 reset invalid", {80'd0, invalid_o}, 81'd0);
        rst_n = 1'b1;
        for (int op = 0; op < 2; op++) begin
            apply(op[0], {1'b0, 15'd0, 64'd0});                          // R4 +0
            apply(op[0], {1'b1, 15'd0, 64'd0});                          // R4 -0
            apply(op[0], {1'b0, 15'h7FFF, 64'h8000_0000_0000_0000});     // R3 +inf
            apply(op[0], {1'b1, 15'h7FFF, 64'h0000_0000_0000_0000});     // R3 inf, integer bit clear
            apply(op[0], {1'b0, 15'h7FFF, 64'hC000_0000_0000_1234});     // R2 quiet
            apply(op[0], {1'b1, 15'h7FFF, 64'h8000_0000_0000_0001});     // R2 signaling
            apply(op[0], {1'b1, 15'd0, 64'd1});                          // R5 smallest subnormal
            apply(op[0], {1'b0, 15'd0, 64'h4000_0000_0000_0000});        // R5 lzc 1
            apply(op[0], {1'b0, 15'h3FFF, 64'h8000_0000_0000_0000});     // R7 d = 0
            apply(op[0], {1'b1, 15'h7FFE, 64'hFFFF_FFFF_FFFF_FFFF});     // R7 max
            apply(op[0], {1'b0, 15'd1, 64'h8000_0000_0000_0001});        // R7 min normal
            apply(op[0], {1'b0, 15'h4000, 64'h1234_5678_9ABC_DEF0});     // R8 unnormal kept
        end
        for (int i = 0; i < 600; i++) begin
            apply(1'($urandom), rand_op());
        end
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(5 * 20000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule